// File: doc/BRIEF.md
# Serial Receive Interrupt Flag Unit

This unit collects the event pulses that a serial receiver produces and turns them into interrupt state for a CPU. It keeps two sticky flags, one for receive errors (parity, framing or overrun) and one for a finished reception. Each flag has its own mask bit. A single interrupt request line goes to the CPU, and a global CPU interrupt-enable input gates that line. Software clears a flag by writing a 1 to its bit, and it can read the flags and masks together through a status view.

The unit also sets the order in which the two flags rise. In asynchronous mode, a reception that ends with a parity or framing error raises the error flag first. The completion flag follows after a lead that depends on the clock source. With the divided oscillator as the source, the lead is a fixed number of system cycles, equal to half a period of the divided clock. With the programmable timer as the source, the completion flag waits for the next timer underflow strobe. A reception that overruns never raises the completion flag. A small arbiter keeps clock-synchronous transfers half duplex, because that mode shares one clock line between transmit and receive.

Top module: `rxirq_unit`

## Requirements
- R1: A pulse on `evt_parity`, `evt_frame` or `evt_overrun` sets the error flag (`stat[0]`) at the next clock edge.
- R2: Both flags set on their events whatever their mask bits hold; the masks only gate `irq`.
- R3: `irq` is a register. One cycle after a cycle in which `cpu_ie` is 1 and some flag is 1 with its mask bit 1, `irq` is 1; otherwise it is 0 one cycle later.
- R4: A write with `reg_addr`=0 clears each flag whose bit in `reg_wdata` is 1 (bit 0 error, bit 1 completion) and leaves flags under 0 bits unchanged. A set event in the same cycle wins over the clear.
- R5: A synchronous reset (`rst`=1) brings both flags, both masks, `irq`, `rx_active` and `tx_active` to 0.
- R6: In asynchronous mode (`sync_mode`=0) with `clk_sel`=0, an `evt_done` pulse together with a parity or framing error sets the completion flag exactly HALF_DIV cycles after the error flag.
- R7: In asynchronous mode with `clk_sel`=1, that completion flag sets at the first clock edge after the `evt_done` edge at which `tmr_uflow` is 1.
- R8: An `evt_done` without error, or any `evt_done` in clock-synchronous mode (`sync_mode`=1), sets the completion flag at the next edge.
- R9: An `evt_overrun` in the same cycle as `evt_done` keeps the completion flag from setting. Any `evt_overrun` also cancels a delayed completion that is still waiting.
- R10: When `sync_mode`=1, `rx_trig` is ignored while `tx_active` is 1 and `tx_trig` is ignored while `rx_active` is 1. If both triggers arrive in the same cycle while idle, transmit wins. When `sync_mode`=0, the two directions are independent. `rx_end` and `tx_end` end an activity.
- R11: A write with `reg_addr`=1 loads the masks from `reg_wdata` (bit 0 error, bit 1 completion). `stat` reads as {completion mask, error mask, completion flag, error flag} in bits 3 down to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_mode | input | 1 | 1 = clock-synchronous mode, 0 = asynchronous |
| clk_sel | input | 1 | Clock source: 0 = divided oscillator, 1 = programmable timer |
| tmr_uflow | input | 1 | Timer underflow strobe |
| evt_parity | input | 1 | Parity error pulse from the receiver |
| evt_frame | input | 1 | Framing error pulse from the receiver |
| evt_overrun | input | 1 | Overrun error pulse from the receiver |
| evt_done | input | 1 | Reception finished pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = flag clear register, 1 = mask register |
| reg_wdata | input | 2 | Write data, bit 0 error, bit 1 completion |
| stat | output | 4 | Status view {mask_done, mask_err, flag_done, flag_err} |
| cpu_ie | input | 1 | Global CPU interrupt enable |
| irq | output | 1 | Registered interrupt request |
| rx_trig | input | 1 | Receive trigger pulse |
| tx_trig | input | 1 | Transmit trigger pulse |
| rx_end | input | 1 | Receive activity end pulse |
| tx_end | input | 1 | Transmit activity end pulse |
| rx_active | output | 1 | Receive activity in progress |
| tx_active | output | 1 | Transmit activity in progress |

## Verification
The hardest states to reach from the ports are those in which a delayed completion is still waiting. These include an overrun that arrives during the wait, a timer strobe that arrives in the very cycle of the error event, and a flag clear that coincides with a set. The stimulus reaches them with exact cycle counting. It holds the underflow strobe low for several cycles before releasing it, and it pulses an overrun on its own one cycle after a delayed completion has been armed. Where the lead has to be measured, it counts cycles from the error flag to the completion flag instead of sampling at fixed points.

// File: rtl/rxirq_pkg.sv
package rxirq_pkg;
  localparam int NFLAG     = 2;
  localparam int FLAG_ERR  = 0;
  localparam int FLAG_DONE = 1;
  localparam logic ADDR_FLAGS = 1'b0;
  localparam logic ADDR_MASK  = 1'b1;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/rxirq_cmpl_delay.sv
// Holds a completion back after an error: a fixed cycle count or the next timer strobe.
module rxirq_cmpl_delay #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic cancel,
  input  logic use_timer,
  input  logic tmr_uflow,
  output logic fire,
  output logic pend
);
  localparam int CNT_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(HALF_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  assign fire = pend_q && (use_timer ? tmr_uflow : (cnt_q == '0));
  assign pend = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel) begin
      pend_q <= 1'b0;
    end else if (load) begin
      pend_q <= 1'b1;
      cnt_q  <= CNT_LOAD;
    end else if (fire) begin
      pend_q <= 1'b0;
    end else if (pend_q && !use_timer) begin
      cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/rxirq_flag_bank.sv
// Sticky flags with write-one-to-clear, mask register and registered request.
module rxirq_flag_bank import rxirq_pkg::*; (
  input  logic      clk,
  input  logic      rst,
  input  flag_vec_t set_i,
  input  flag_vec_t clr_i,
  input  logic      mask_we,
  input  flag_vec_t mask_wdata,
  input  logic      cpu_ie,
  output flag_vec_t flags_o,
  output flag_vec_t mask_o,
  output logic      irq_o
);
  flag_vec_t flag_q, mask_q;
  logic      irq_q;

  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        flag_q[i] <= set_i[i] | (flag_q[i] & ~clr_i[i]);
        if (mask_we) mask_q[i] <= mask_wdata[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cpu_ie && |(flag_q & mask_q);
  end

  assign flags_o = flag_q;
  assign mask_o  = mask_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/rxirq_hd_arb.sv
// Trigger acceptance; half duplex when the shared clock line is in use.
module rxirq_hd_arb (
  input  logic clk,
  input  logic rst,
  input  logic sync_mode,
  input  logic rx_trig,
  input  logic tx_trig,
  input  logic rx_end,
  input  logic tx_end,
  output logic rx_active,
  output logic tx_active
);
  logic rx_q, tx_q, rx_go, tx_go;

  assign tx_go = tx_trig && (!sync_mode || !rx_q);
  assign rx_go = rx_trig && (!sync_mode || (!tx_q && !tx_trig));

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_q <= 1'b0;
      tx_q <= 1'b0;
    end else begin
      rx_q <= rx_go || (rx_q && !rx_end);
      tx_q <= tx_go || (tx_q && !tx_end);
    end
  end

  assign rx_active = rx_q;
  assign tx_active = tx_q;
endmodule

// File: rtl/rxirq_unit.sv
module rxirq_unit import rxirq_pkg::*; #(
  parameter int HALF_DIV = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_mode,
  input  logic       clk_sel,
  input  logic       tmr_uflow,
  input  logic       evt_parity,
  input  logic       evt_frame,
  input  logic       evt_overrun,
  input  logic       evt_done,
  input  logic       reg_we,
  input  logic       reg_addr,
  input  logic [1:0] reg_wdata,
  output logic [3:0] stat,
  input  logic       cpu_ie,
  output logic       irq,
  input  logic       rx_trig,
  input  logic       tx_trig,
  input  logic       rx_end,
  input  logic       tx_end,
  output logic       rx_active,
  output logic       tx_active
);
  logic      err_evt, need_dly, dly_fire, cmpl_pend;
  flag_vec_t set_vec, clr_vec, flags, mask;

  assign err_evt  = evt_parity | evt_frame | evt_overrun;
  assign need_dly = !sync_mode && (evt_parity || evt_frame);

  rxirq_cmpl_delay #(.HALF_DIV(HALF_DIV)) u_dly (
    .clk      (clk),
    .rst      (rst),
    .load     (evt_done && need_dly && !evt_overrun),
    .cancel   (evt_overrun),
    .use_timer(clk_sel),
    .tmr_uflow(tmr_uflow),
    .fire     (dly_fire),
    .pend     (cmpl_pend)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLAG_ERR]  = err_evt;
    set_vec[FLAG_DONE] = dly_fire || (evt_done && !evt_overrun && !need_dly);
    clr_vec = (reg_we && reg_addr == ADDR_FLAGS) ? flag_vec_t'(reg_wdata) : '0;
  end

  rxirq_flag_bank u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_i     (set_vec),
    .clr_i     (clr_vec),
    .mask_we   (reg_we && reg_addr == ADDR_MASK),
    .mask_wdata(flag_vec_t'(reg_wdata)),
    .cpu_ie    (cpu_ie),
    .flags_o   (flags),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  rxirq_hd_arb u_arb (
    .clk      (clk),
    .rst      (rst),
    .sync_mode(sync_mode),
    .rx_trig  (rx_trig),
    .tx_trig  (tx_trig),
    .rx_end   (rx_end),
    .tx_end   (tx_end),
    .rx_active(rx_active),
    .tx_active(tx_active)
  );

  assign stat = {mask, flags};
endmodule

// File: rtl/rxirq_unit_chk.sv
module rxirq_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       sync_mode,
  input logic       evt_parity,
  input logic       evt_frame,
  input logic       evt_overrun,
  input logic       evt_done,
  input logic       reg_we,
  input logic       reg_addr,
  input logic [1:0] reg_wdata,
  input logic [3:0] stat,
  input logic       cpu_ie,
  input logic       irq,
  input logic       rx_active,
  input logic       tx_active,
  input logic       cmpl_pend
);
  // R1 and R2: the error flag sets whatever the mask holds
  assert_err_set_R1: assert property (@(posedge clk) disable iff (rst)
    (evt_parity || evt_frame || evt_overrun) |=> stat[0]);

  assert_irq_gate_R3: assert property (@(posedge clk) disable iff (rst)
    !cpu_ie |=> !irq);

  assert_irq_raise_R3: assert property (@(posedge clk) disable iff (rst)
    (cpu_ie && |(stat[1:0] & stat[3:2])) |=> irq);

  assert_clear_R4: assert property (@(posedge clk) disable iff (rst)
    (reg_we && !reg_addr && reg_wdata[0] && !(evt_parity || evt_frame || evt_overrun))
    |=> !stat[0]);

  // R6 and R7: the error flag leads the completion flag
  assert_err_leads_R6: assert property (@(posedge clk) disable iff (rst)
    (!sync_mode && evt_done && (evt_parity || evt_frame) && !evt_overrun &&
     !stat[1] && !cmpl_pend) |=> (stat[0] && !stat[1]));

  assert_overrun_drop_R9: assert property (@(posedge clk) disable iff (rst)
    (evt_overrun && evt_done && !stat[1] && !cmpl_pend) |=> !stat[1]);

  assert_rx_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && tx_active && !rx_active) |=> !rx_active);

  assert_tx_blocked_R10: assert property (@(posedge clk) disable iff (rst)
    (sync_mode && rx_active && !tx_active) |=> !tx_active);
endmodule

bind rxirq_unit rxirq_unit_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .sync_mode  (sync_mode),
  .evt_parity (evt_parity),
  .evt_frame  (evt_frame),
  .evt_overrun(evt_overrun),
  .evt_done   (evt_done),
  .reg_we     (reg_we),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .stat       (stat),
  .cpu_ie     (cpu_ie),
  .irq        (irq),
  .rx_active  (rx_active),
  .tx_active  (tx_active),
  .cmpl_pend  (cmpl_pend)
);

// File: tb/rxirq_unit_bench.sv
module rxirq_unit_bench;
  localparam int HALF_DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_mode = 0, clk_sel = 0, tmr_uflow = 0;
  logic evt_parity = 0, evt_frame = 0, evt_overrun = 0, evt_done = 0;
  logic reg_we = 0, reg_addr = 0;
  logic [1:0] reg_wdata = 0;
  logic cpu_ie = 0, rx_trig = 0, tx_trig = 0, rx_end = 0, tx_end = 0;
  logic [3:0] stat;
  logic irq, rx_active, tx_active;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  rxirq_unit #(.HALF_DIV(HALF_DIV)) u_rxirq_unit (
    .clk(clk), .rst(rst), .sync_mode(sync_mode), .clk_sel(clk_sel),
    .tmr_uflow(tmr_uflow), .evt_parity(evt_parity), .evt_frame(evt_frame),
    .evt_overrun(evt_overrun), .evt_done(evt_done), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stat(stat), .cpu_ie(cpu_ie),
    .irq(irq), .rx_trig(rx_trig), .tx_trig(tx_trig), .rx_end(rx_end),
    .tx_end(tx_end), .rx_active(rx_active), .tx_active(tx_active)
  );

  // Behavioural reference model
  bit m_err, m_done, m_pend, m_irq, m_rx, m_tx;
  bit [1:0] m_mask;
  int m_rem;

  always @(posedge clk) begin
    if (rst) begin
      m_err = 0; m_done = 0; m_pend = 0; m_irq = 0; m_rx = 0; m_tx = 0;
      m_mask = 0; m_rem = 0;
    end else begin
      bit fire, dly, dset, txok, rxok;
      m_irq = cpu_ie && ((m_err && m_mask[0]) || (m_done && m_mask[1]));
      fire = 0;
      if (m_pend) begin
        if (clk_sel) fire = tmr_uflow;
        else begin
          m_rem = m_rem - 1;
          fire = (m_rem == 0);
        end
      end
      if (fire) m_pend = 0;
      dly  = !sync_mode && (evt_parity || evt_frame);
      dset = fire || (evt_done && !evt_overrun && !dly);
      if (evt_overrun) m_pend = 0;
      else if (evt_done && dly) begin m_pend = 1; m_rem = HALF_DIV; end
      if (reg_we && !reg_addr) begin
        if (reg_wdata[0]) m_err = 0;
        if (reg_wdata[1]) m_done = 0;
      end
      if (evt_parity || evt_frame || evt_overrun) m_err = 1;
      if (dset) m_done = 1;
      if (reg_we && reg_addr) m_mask = reg_wdata;
      txok = tx_trig && (!sync_mode || !m_rx);
      rxok = rx_trig && (!sync_mode || (!m_tx && !tx_trig));
      m_tx = txok || (m_tx && !tx_end);
      m_rx = rxok || (m_rx && !rx_end);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Comparison against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk(stat == {m_mask, m_done, m_err}, "R11 status vs model", stat, {m_mask, m_done, m_err});
      chk(irq == m_irq, "R3 irq vs model", irq, m_irq);
      chk({rx_active, tx_active} == {m_rx, m_tx}, "R10 activity vs model",
          {rx_active, tx_active}, {m_rx, m_tx});
    end
  end

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic quiet();
    evt_parity = 0; evt_frame = 0; evt_overrun = 0; evt_done = 0;
    reg_we = 0; tmr_uflow = 0; rx_trig = 0; tx_trig = 0; rx_end = 0; tx_end = 0;
  endtask

  task automatic wr(input logic a, input logic [1:0] d);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    tick(); tick();
    rst = 0;
    tick();
    // R5 reset state
    chk(stat == 4'h0 && !irq && !rx_active && !tx_active, "R5 reset state",
        {stat, irq, rx_active, tx_active}, 0);

    // R6, R1, R2: parity with done, masks at 0, divided source
    evt_parity = 1; evt_done = 1;
    tick(); quiet();
    chk(stat[1:0] == 2'b01, "R1 R2 error flag first", stat[1:0], 2'b01);
    n = 0;
    while (!stat[1] && n < 20) begin tick(); n++; end
    chk(n == HALF_DIV, "R6 lead cycles", n, HALF_DIV);
    chk(!irq, "R2 mask gates irq", irq, 0);

    // R4 clear both
    wr(1'b0, 2'b11);
    chk(stat[1:0] == 2'b00, "R4 clear both flags", stat[1:0], 0);

    // R7 timer source, strobe in the event cycle is not taken
    wr(1'b1, 2'b11);
    clk_sel = 1; evt_frame = 1; evt_done = 1; tmr_uflow = 1;
    tick(); quiet();
    chk(stat[1:0] == 2'b01, "R7 error before strobe", stat[1:0], 2'b01);
    tick(); tick(); tick();
    chk(!stat[1], "R7 waits for strobe", stat[1], 0);
    tmr_uflow = 1;
    tick(); quiet();
    chk(stat[1], "R7 completion on strobe", stat[1], 1);
    chk(!irq, "R3 cpu_ie low blocks irq", irq, 0);
    cpu_ie = 1;
    tick();
    chk(irq, "R3 irq raised", irq, 1);
    wr(1'b0, 2'b11);
    chk(irq, "R3 irq still registered", irq, 1);
    tick();
    chk(!irq, "R3 irq drops after clear", irq, 0);
    clk_sel = 0;

    // R9 overrun with done
    evt_overrun = 1; evt_done = 1;
    tick(); quiet();
    chk(stat[1:0] == 2'b01, "R9 overrun sets error only", stat[1:0], 2'b01);
    repeat (HALF_DIV + 2) tick();
    chk(!stat[1], "R9 no completion", stat[1], 0);
    wr(1'b0, 2'b01);
    // R9 overrun cancels pending delay
    evt_parity = 1; evt_done = 1;
    tick(); quiet();
    evt_overrun = 1;
    tick(); quiet();
    repeat (HALF_DIV + 2) tick();
    chk(!stat[1], "R9 pending cancelled", stat[1], 0);
    wr(1'b0, 2'b11);

    // R8 clean completion and sync mode completion
    evt_done = 1;
    tick(); quiet();
    chk(stat[1:0] == 2'b10, "R8 clean completion", stat[1:0], 2'b10);
    wr(1'b0, 2'b10);
    sync_mode = 1; evt_parity = 1; evt_done = 1;
    tick(); quiet();
    chk(stat[1:0] == 2'b11, "R8 sync mode no delay", stat[1:0], 2'b11);
    sync_mode = 0;

    // R4 set wins over clear, zero bits do nothing
    reg_we = 1; reg_addr = 0; reg_wdata = 2'b01; evt_frame = 1;
    tick(); quiet();
    chk(stat[0], "R4 set wins over clear", stat[0], 1);
    wr(1'b0, 2'b00);
    chk(stat[1:0] == 2'b11, "R4 zero bits ignored", stat[1:0], 2'b11);

    // R11 mask view
    wr(1'b1, 2'b10);
    chk(stat[3:2] == 2'b10, "R11 mask readback", stat[3:2], 2'b10);
    wr(1'b0, 2'b11);

    // R10 half duplex
    sync_mode = 1; tx_trig = 1;
    tick(); quiet();
    rx_trig = 1;
    tick(); quiet();
    chk(tx_active && !rx_active, "R10 rx ignored during tx", {rx_active, tx_active}, 2'b01);
    tx_end = 1;
    tick(); quiet();
    rx_trig = 1;
    tick(); quiet();
    tx_trig = 1;
    tick(); quiet();
    chk(rx_active && !tx_active, "R10 tx ignored during rx", {rx_active, tx_active}, 2'b10);
    rx_end = 1;
    tick(); quiet();
    rx_trig = 1; tx_trig = 1;
    tick(); quiet();
    chk(tx_active && !rx_active, "R10 tx wins tie", {rx_active, tx_active}, 2'b01);
    sync_mode = 0; rx_trig = 1;
    tick(); quiet();
    chk(tx_active && rx_active, "R10 async full duplex", {rx_active, tx_active}, 2'b11);
    tick();

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule